// File: doc/BRIEF.md
# Translating Address Unit with Hardware Table Walk

This unit turns a 32-bit virtual address into a physical address for a processor pipeline. A small, fully associative translation cache holds recent page mappings. On a hit the mapping goes straight to a permission stage. On a miss a hardware walker reads two levels of page table through a single-outstanding memory read port, starting from a root-table base that the pipeline supplies. The walker then refills the cache and the lookup is retried. The retried lookup hits and reaches the same permission stage.

Each accepted request gets exactly one response. The response carries either the physical address or one of two distinct fault codes: a page fault when the mapping is not resident, and a protection fault when the mode or access kind is not allowed. A flush input empties the translation cache in one cycle.

Top module: `mmu_xlate`

## Requirements
- R1: The virtual address splits into a level-1 index (bits 31:22), a level-2 index (bits 21:12) and a page offset (bits 11:0). The first walk read is at {root_base[31:12], level-1 index, 2'b00}. The second walk read is at {level-1 entry[31:12], level-2 index, 2'b00}.
- R2: A table entry holds a frame or next-table number in bits 31:12, a writable flag in bit 3, a user flag in bit 2 and a residency code in bits 1:0. Code 2'b01 means resident, 2'b10 means held in secondary storage, and 2'b00 or 2'b11 mean nonexistent.
- R3: A request whose page is held in the translation cache is answered without any memory read.
- R4: On a miss, the unit reads the two table levels, refills the cache and retries the lookup. A permitted access then returns rsp_paddr = {leaf[31:12], offset} with rsp_fault = 0.
- R5: A non-resident entry at either level gives rsp_fault = 1 with rsp_paddr = 0. A non-resident level-1 entry ends the walk after one read. A faulting walk does not refill the cache, so repeating the address walks again.
- R6: A user-mode access to a page without the user flag, or a write in any mode to a page without the writable flag, gives rsp_fault = 2 with rsp_paddr = 0.
- R7: Every accepted request produces exactly one rsp_valid pulse of one cycle. req_ready stays low from acceptance until that pulse.
- R8: A flush pulse invalidates every cache entry, so each page is walked again afterwards.
- R9: The cache holds ENTRIES (default 8) mappings and refills them in round-robin order. The ninth distinct refill replaces the first one and leaves the second in place.
- R10: At most one memory read is outstanding. mem_req is not raised again until mem_rvalid has returned the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cache entries |
| root_base | input | 32 | Byte address of the level-1 table (page aligned) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench checks that a fault at level 1 stops after one read. A design that read level 2 anyway would show an extra memory read. It also repeats faulting addresses to catch a design that refilled on a page fault, which would then answer the repeat from the cache. It fills one more page than the cache holds, then probes the second and the first page. A pointer that did not rotate, or that evicted the wrong slot, changes the read count. Protection cases use kernel-mode writes and user-mode reads, so that a check that confused the two flags or ignored the mode returns the wrong fault code. The bench also checks the exact walk addresses, which exposes swapped index fields.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
   localparam int VA_W   = 32;
   localparam int OFF_W  = 12;
   localparam int IDX_W  = 10;
   localparam int PN_W   = VA_W - OFF_W;

   localparam logic [1:0] PTE_RESIDENT = 2'b01;
   localparam logic [1:0] PTE_SWAPPED  = 2'b10;

   localparam int PTE_USR_BIT = 2;
   localparam int PTE_WR_BIT  = 3;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_PAGE = 2'd1,
      FLT_PROT = 2'd2
   } fault_e;

   typedef struct packed {
      logic [PN_W-1:0] ppn;
      logic            usr;
      logic            wrt;
   } map_t;
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb
   import mmu_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [PN_W-1:0] lk_vpn,
   output logic            lk_hit,
   output map_t            lk_map,
   input  logic            fill_en,
   input  logic [PN_W-1:0] fill_vpn,
   input  map_t            fill_map
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("mmu_tlb: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [PN_W-1:0]    vpn_q [ENTRIES];
   map_t               map_q [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
   end

   always_comb begin
      lk_map = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) lk_map = lk_map | map_q[i];
      end
   end
   assign lk_hit = |match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (fill_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ptr_q == PTR_W'(i)) vld_q[i] <= 1'b1;
         end
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ptr_q == PTR_W'(i)) begin
               vpn_q[i] <= fill_vpn;
               map_q[i] <= fill_map;
            end
         end
      end
   end

   // R9: refills never leave two valid copies of one page
   a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R8: after a flush nothing hits
   a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);
endmodule

// File: rtl/mmu_walk.sv
module mmu_walk
   import mmu_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PN_W-1:0] vpn,
   input  logic [PN_W-1:0] root_pg,
   output logic            mem_req,
   output logic [VA_W-1:0] mem_addr,
   input  logic            mem_rvalid,
   input  logic [VA_W-1:0] mem_rdata,
   output logic            done,
   output logic            fault,
   output map_t            leaf
);
   typedef enum logic [2:0] {W_IDLE, W_L1, W_L1W, W_L2, W_L2W} wst_e;

   wst_e            st_q;
   logic [PN_W-1:0] vpn_q;
   logic [PN_W-1:0] base_q;
   logic [IDX_W-1:0] idx;
   logic            unused_bits;

   assign unused_bits = ^mem_rdata[OFF_W-1:4];
   assign idx      = (st_q == W_L1) ? vpn_q[PN_W-1 -: IDX_W] : vpn_q[IDX_W-1:0];
   assign mem_req  = (st_q == W_L1) || (st_q == W_L2);
   assign mem_addr = {base_q, idx, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         vpn_q  <= '0;
         base_q <= '0;
         done   <= 1'b0;
         fault  <= 1'b0;
         leaf   <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            W_IDLE: if (start) begin
               vpn_q  <= vpn;
               base_q <= root_pg;
               st_q   <= W_L1;
            end
            W_L1: st_q <= W_L1W;
            W_L1W: if (mem_rvalid) begin
               if (mem_rdata[1:0] == PTE_RESIDENT) begin
                  base_q <= mem_rdata[VA_W-1:OFF_W];
                  st_q   <= W_L2;
               end else begin
                  done  <= 1'b1;
                  fault <= 1'b1;
                  st_q  <= W_IDLE;
               end
            end
            W_L2: st_q <= W_L2W;
            W_L2W: if (mem_rvalid) begin
               done      <= 1'b1;
               fault     <= (mem_rdata[1:0] != PTE_RESIDENT);
               leaf.ppn  <= mem_rdata[VA_W-1:OFF_W];
               leaf.usr  <= mem_rdata[PTE_USR_BIT];
               leaf.wrt  <= mem_rdata[PTE_WR_BIT];
               st_q      <= W_IDLE;
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end

   // R10: a read request is a single-cycle pulse, never back to back
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R5: a walk reports completion as a single pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
   import mmu_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush,
   input  logic [31:0] root_base,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_vaddr,
   input  logic        req_write,
   input  logic        req_user,
   output logic        rsp_valid,
   output logic [31:0] rsp_paddr,
   output logic [1:0]  rsp_fault,
   output logic        mem_req,
   output logic [31:0] mem_addr,
   input  logic        mem_rvalid,
   input  logic [31:0] mem_rdata
);
   typedef enum logic [1:0] {T_IDLE, T_LOOK, T_WALK, T_CHECK} tst_e;

   tst_e            st_q;
   logic [VA_W-1:0] va_q;
   logic            wr_q, usr_q;
   map_t            chk_q;
   logic            hit, walk_start, walk_done, walk_fault, fill;
   map_t            hit_map, walk_map;
   logic            deny;
   logic            unused_root;

   assign unused_root = ^root_base[OFF_W-1:0];
   assign req_ready   = (st_q == T_IDLE);
   assign walk_start  = (st_q == T_LOOK) && !hit;
   assign fill        = (st_q == T_WALK) && walk_done && !walk_fault;
   assign deny        = (usr_q && !chk_q.usr) || (wr_q && !chk_q.wrt);

   mmu_tlb #(.ENTRIES(ENTRIES)) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .lk_vpn   (va_q[VA_W-1:OFF_W]),
      .lk_hit   (hit),
      .lk_map   (hit_map),
      .fill_en  (fill),
      .fill_vpn (va_q[VA_W-1:OFF_W]),
      .fill_map (walk_map)
   );

   mmu_walk u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (walk_start),
      .vpn        (va_q[VA_W-1:OFF_W]),
      .root_pg    (root_base[VA_W-1:OFF_W]),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .done       (walk_done),
      .fault      (walk_fault),
      .leaf       (walk_map)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= T_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         usr_q     <= 1'b0;
         chk_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st_q)
            T_IDLE: if (req_valid) begin
               va_q  <= req_vaddr;
               wr_q  <= req_write;
               usr_q <= req_user;
               st_q  <= T_LOOK;
            end
            T_LOOK: begin
               if (hit) begin
                  chk_q <= hit_map;
                  st_q  <= T_CHECK;
               end else begin
                  st_q <= T_WALK;
               end
            end
            T_WALK: if (walk_done) begin
               if (walk_fault) begin
                  rsp_valid <= 1'b1;
                  rsp_paddr <= '0;
                  rsp_fault <= FLT_PAGE;
                  st_q      <= T_IDLE;
               end else begin
                  st_q <= T_LOOK;
               end
            end
            T_CHECK: begin
               rsp_valid <= 1'b1;
               rsp_fault <= deny ? FLT_PROT : FLT_NONE;
               rsp_paddr <= deny ? '0 : {chk_q.ppn, va_q[OFF_W-1:0]};
               st_q      <= T_IDLE;
            end
            default: st_q <= T_IDLE;
         endcase
      end
   end

   // R7: a response is one cycle wide and follows a busy cycle
   a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r7_busy_before_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!req_ready));
   // R6 / R5: a faulting response never carries an address
   a_r6_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == 32'd0);
   // R2: only the three defined codes leave the unit
   a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault != 2'd3);
   // R10: no memory request while a response is being issued
   a_r10_idle_mem: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);
endmodule

// File: tb/mmu_xlate_tb.sv
module mmu_xlate_tb;
   localparam logic [31:0] ROOT = 32'h0010_0000;
   localparam int NVEC = 12;
   // {vaddr, write, user, expected fault code}
   localparam logic [35:0] VEC [NVEC] = '{
      {32'h0000_0123, 1'b0, 1'b1, 2'd0},
      {32'h0000_0456, 1'b1, 1'b1, 2'd0},
      {32'h0040_1ABC, 1'b0, 1'b1, 2'd2},
      {32'h0040_1ABC, 1'b0, 1'b0, 2'd0},
      {32'h0080_2010, 1'b1, 1'b0, 2'd2},
      {32'h0080_2010, 1'b0, 1'b1, 2'd0},
      {32'h00C0_7000, 1'b0, 1'b0, 2'd1},
      {32'h00C0_9000, 1'b0, 1'b0, 2'd1},
      {32'h0100_0000, 1'b0, 1'b0, 2'd1},
      {32'h0240_0000, 1'b0, 1'b0, 2'd1},
      {32'h0000_3FF0, 1'b1, 1'b0, 2'd2},
      {32'h00C0_4008, 1'b0, 1'b1, 2'd0}
   };

   logic clk = 0, rst_n = 0, flush = 0;
   logic req_valid = 0, req_write = 0, req_user = 0;
   logic [31:0] req_vaddr = '0;
   logic req_ready, rsp_valid, mem_req;
   logic [31:0] rsp_paddr, mem_addr;
   logic [1:0] rsp_fault;
   logic mem_rvalid;
   logic [31:0] mem_rdata;

   int checks = 0, errors = 0, reads = 0;
   logic overlap = 0, pend = 0;
   logic [31:0] addr_q, last_addr, prev_addr;
   int cnt, lat = 0;

   always #5 clk = ~clk;

   mmu_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .root_base(ROOT),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [19:0] exp_ppn(logic [31:0] va);
      return {va[31:22] ^ 10'h155, va[21:12]};
   endfunction

   function automatic logic [31:0] table_word(logic [31:0] a);
      logic [19:0] pg = a[31:12];
      logic [9:0]  ix = a[11:2];
      logic [9:0]  l1;
      logic [1:0]  stc;
      if (pg == ROOT[31:12]) begin
         if (ix < 10'd4) return {20'h00200 + {10'd0, ix}, 10'd0, 2'b01};
         if (ix == 10'd4) return {20'h0, 10'd0, 2'b10};
         return 32'h0;
      end
      if (pg >= 20'h00200 && pg <= 20'h00203) begin
         l1  = pg[9:0] - 10'h200;
         stc = (ix == 10'd7) ? 2'b10 : (ix == 10'd9) ? 2'b00 : 2'b01;
         return {l1 ^ 10'h155, ix, 8'd0, ~ix[1], ~ix[0], stc};
      end
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         if (pend) overlap <= 1'b1;
         pend <= 1'b1; addr_q <= mem_addr; cnt <= lat; reads <= reads + 1;
         prev_addr <= last_addr; last_addr <= mem_addr;
      end else if (pend) begin
         if (cnt == 0) begin
            mem_rvalid <= 1'b1; mem_rdata <= table_word(addr_q);
            pend <= 1'b0; lat <= (lat + 1) % 4;
         end else cnt <= cnt - 1;
      end
   end

   task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [31:0] va, input logic wr, input logic usr,
                         output logic [1:0] flt, output logic [31:0] pa, output int nrd);
      int r0 = reads;
      logic busy_ok = 1;
      int t = 0;
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      while (!rsp_valid && t < 300) begin
         if (req_ready) busy_ok = 0;
         @(negedge clk); t++;
      end
      flt = rsp_fault; pa = rsp_paddr; nrd = reads - r0;
      check("R7 ready low while busy and response seen", busy_ok && t < 300, {31'd0, busy_ok}, 32'd1);
      @(negedge clk);
      check("R7 single-cycle response", !rsp_valid, {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1; @(negedge clk); flush = 0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0] f; logic [31:0] p; int n;
      logic [31:0] va;
      repeat (3) @(negedge clk);
      check("reset rsp_valid low", !rsp_valid, {31'd0, rsp_valid}, 0);
      check("reset req_ready high", req_ready, {31'd0, req_ready}, 1);
      check("reset mem_req low", !mem_req, {31'd0, mem_req}, 0);
      rst_n = 1;

      // R2 R4 R5 R6: table of vectors
      for (int i = 0; i < NVEC; i++) begin
         va = VEC[i][35:4];
         access(va, VEC[i][3], VEC[i][2], f, p, n);
         check($sformatf("R2 R4 R5 R6 vector %0d fault code", i), f == VEC[i][1:0], {30'd0, f}, {30'd0, VEC[i][1:0]});
         check($sformatf("R4 R6 vector %0d address", i),
               p == ((VEC[i][1:0] == 2'd0) ? {exp_ppn(va), va[11:0]} : 32'd0), p,
               (VEC[i][1:0] == 2'd0) ? {exp_ppn(va), va[11:0]} : 32'd0);
      end

      // R8 and R1: after flush the page walks again at the right addresses
      do_flush();
      access(32'h0040_1ABC, 1'b0, 1'b0, f, p, n);
      check("R8 flushed page walks again", n == 2, n, 2);
      check("R1 level-1 read address", prev_addr == {ROOT[31:12], 10'd1, 2'b00}, prev_addr, {ROOT[31:12], 10'd1, 2'b00});
      check("R1 level-2 read address", last_addr == {20'h00201, 10'd1, 2'b00}, last_addr, {20'h00201, 10'd1, 2'b00});
      // R3: hit needs no read
      access(32'h0040_1ABC, 1'b0, 1'b0, f, p, n);
      check("R3 hit without memory read", n == 0, n, 0);
      check("R3 hit address", p == {exp_ppn(32'h0040_1ABC), 12'hABC}, p, {exp_ppn(32'h0040_1ABC), 12'hABC});

      // R5: faults do not refill; level-1 fault stops after one read
      access(32'h00C0_7000, 1'b0, 1'b0, f, p, n);
      access(32'h00C0_7000, 1'b0, 1'b0, f, p, n);
      check("R5 page fault not cached", n == 2 && f == 2'd1, n, 2);
      access(32'h0240_0000, 1'b0, 1'b0, f, p, n);
      check("R5 level-1 fault single read", n == 1 && f == 2'd1, n, 1);

      // R9: round-robin replacement over 8 entries
      do_flush();
      for (int k = 0; k < 9; k++) access({10'd0, 10'(4 * k), 12'h010}, 1'b0, 1'b1, f, p, n);
      access({10'd0, 10'd4, 12'h010}, 1'b0, 1'b1, f, p, n);
      check("R9 second refill survives", n == 0, n, 0);
      access({10'd0, 10'd0, 12'h010}, 1'b0, 1'b1, f, p, n);
      check("R9 first refill evicted", n == 2, n, 2);

      check("R10 no overlapping reads", !overlap, {31'd0, overlap}, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule